// File: doc/BRIEF.md
# Ring-Oscillator Count Comparator

This block turns the free-running pulses of a ring-oscillator array into a response word for device authentication. A start pulse loads a challenge made of three parts: an observation count, the index of the row that acts as the timebase, and a list of rows to sample. Loading the challenge clears every row counter and turns the oscillator array on. Each oscillator output is brought into the system clock domain, and its rising edges are counted per row.

The timebase is one of the oscillators rather than the system clock. The run ends in the cycle where the timebase row's count equals the observation count. At that point the array is switched off and the counts are frozen. Each selected row is then compared with the timebase count. A row at or above the timebase count gives a 1, and a row below it gives a 0. A done flag marks the result as valid.

A longer observation count lets more oscillator periods accumulate, which averages out short-term jitter. Because both sides of each comparison are measured on the same die, shared drift in supply and temperature cancels.

Top module: `ro_response_gen`

## Requirements
- R1: After reset, osc_en, done and response are all 0.
- R2: A start seen while idle or after completion clears every row counter and raises osc_en on the next clock edge. osc_en is 0 whenever no run is active.
- R3: Each oscillator input passes through two synchronizing flops. A row counter adds exactly one per rising edge, however long the high phase lasts, and only while a run is active.
- R4: The run stops in the cycle where the count of the timebase row (index ref_row) equals obs_count. On that edge osc_en falls and done rises together.
- R5: Response bit j is 1 when the count of the row named by sel_rows[j*IDX_W +: IDX_W] is greater than or equal to the timebase count, and 0 when it is lower. The counts used are those frozen at the stop.
- R6: The selection may name any rows, including the same row twice or the timebase row itself. The timebase row always yields a 1.
- R7: With obs_count = 0 the run ends one cycle after it starts, no edge is counted, and every response bit is 1.
- R8: A row counter holds at its all-ones value instead of wrapping.
- R9: done and response hold their values until the next accepted start. A start during a run is ignored.
- R10: obs_count, ref_row and sel_rows are captured at an accepted start. Changes to them during a run have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the challenge and begin a run |
| osc_in | input | NUM_ROWS | Raw oscillator outputs, one per row |
| obs_count | input | CNT_W | Timebase count at which the run stops |
| ref_row | input | IDX_W | Index of the timebase row |
| sel_rows | input | RESP_BITS*IDX_W | Row index for each response bit, field j at bits j*IDX_W |
| osc_en | output | 1 | Turns the oscillator array on |
| done | output | 1 | Response valid |
| response | output | RESP_BITS | Comparison result per selected row |

## Verification
Two events can fall on the same clock edge: the timebase count reaching the observation count, and another row's counter incrementing. The bench provokes this by raising every active oscillator at the same instant in each round. Rows that keep pace with the timebase therefore end with a count equal to it, and must produce a 1. The bench compares each result with counts it derives from each row's pulse rate and from the number of rounds that run before the stop. It also checks that exactly that number of rounds ran while osc_en was high.

// File: rtl/ro_response_gen.sv
module ro_response_gen #(
  parameter int NUM_ROWS  = 8,
  parameter int RESP_BITS = 4,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_ROWS-1:0]        osc_in,
  input  logic [CNT_W-1:0]           obs_count,
  input  logic [IDX_W-1:0]           ref_row,
  input  logic [RESP_BITS*IDX_W-1:0] sel_rows,
  output logic                       osc_en,
  output logic                       done,
  output logic [RESP_BITS-1:0]       response
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_ROWS-1:0]        s1, s2, s3;
  logic [NUM_ROWS-1:0]        rise;
  logic [CNT_W-1:0]           cnt [NUM_ROWS];
  logic                       running;
  logic [CNT_W-1:0]           obs_q;
  logic [IDX_W-1:0]           ref_q;
  logic [RESP_BITS*IDX_W-1:0] sel_q;
  logic [CNT_W-1:0]           ref_cnt;
  logic                       hit, launch;
  logic [RESP_BITS-1:0]       resp_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= osc_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise    = s2 & ~s3;
  assign ref_cnt = cnt[ref_q];
  assign hit     = running && (ref_cnt == obs_q);
  assign launch  = start && !running;
  assign osc_en  = running;

  for (genvar w = 0; w < NUM_ROWS; w++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[w] <= '0;
      else if (launch)
        cnt[w] <= '0;
      else if (running && !hit && rise[w] && cnt[w] != CNT_MAX)
        cnt[w] <= cnt[w] + 1'b1;
    end

    AST_SATURATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[w] == CNT_MAX && !launch) |=> (cnt[w] == CNT_MAX)); // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> (cnt[w] == $past(cnt[w]) || cnt[w] == $past(cnt[w]) + 1'b1)); // R3
  end

  for (genvar j = 0; j < RESP_BITS; j++) begin : g_bit
    assign resp_next[j] = cnt[sel_q[j*IDX_W +: IDX_W]] >= ref_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      done     <= 1'b0;
      response <= '0;
      obs_q    <= '0;
      ref_q    <= '0;
      sel_q    <= '0;
    end else if (launch) begin
      running <= 1'b1;
      done    <= 1'b0;
      obs_q   <= obs_count;
      ref_q   <= ref_row;
      sel_q   <= sel_rows;
    end else if (hit) begin
      running  <= 1'b0;
      done     <= 1'b1;
      response <= resp_next;
    end
  end

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> !done); // R2
  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && ref_cnt != obs_q) |=> osc_en); // R4
  AST_STOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $rose(done)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(response))); // R9

endmodule

// File: tb/sim_ro_response_gen.sv
module sim_ro_response_gen;
  localparam int NR = 8;
  localparam int RB = 4;
  localparam int CW = 6;
  localparam int IW = 3;
  localparam int MAXC = 63;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [NR-1:0] osc_in = '0;
  logic [CW-1:0] obs_count = '0;
  logic [IW-1:0] ref_row = '0;
  logic [RB*IW-1:0] sel_rows = '0;
  logic osc_en, done;
  logic [RB-1:0] response;

  int errors = 0;
  int checks = 0;
  int div [NR];
  int sel [RB];
  bit finished = 0;

  always #10 clk = ~clk;

  ro_response_gen #(.NUM_ROWS(NR), .RESP_BITS(RB), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .osc_in(osc_in),
    .obs_count(obs_count), .ref_row(ref_row), .sel_rows(sel_rows),
    .osc_en(osc_en), .done(done), .response(response));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  // Runs one challenge; all active rows rise at the same instant of a round.
  task automatic run_case(input string req, input int rref, input int obs, input bit inject);
    int rounds = 0;
    int k_exp, c;
    logic [RB-1:0] exp_resp;
    ref_row = IW'(rref);
    obs_count = CW'(obs);
    for (int j = 0; j < RB; j++) sel_rows[j*IW +: IW] = IW'(sel[j]);
    pulse_start();
    check({req, " R2 osc_en after start"}, 32'(osc_en), 1);
    forever begin
      if (!osc_en) break;
      for (int w = 0; w < NR; w++) osc_in[w] = (rounds % div[w]) == 0;
      rounds++;
      @(negedge clk); @(negedge clk);
      osc_in = '0;
      if (inject && rounds == 2) begin
        start = 1; obs_count = CW'(1); ref_row = IW'(rref + 1); sel_rows = '1;
        @(negedge clk);
        start = 0;
        check({req, " R9 start ignored in run"}, 32'(osc_en), 1);
        repeat (7) @(negedge clk);
      end else
        repeat (8) @(negedge clk);
    end
    k_exp = (obs == 0) ? 0 : (obs - 1) * div[rref] + 1;
    if (obs == 0) exp_resp = '1;
    else
      for (int j = 0; j < RB; j++) begin
        c = (k_exp - 1) / div[sel[j]] + 1;
        if (c > MAXC) c = MAXC;
        exp_resp[j] = c >= obs;
      end
    if (obs != 0) check({req, " R4 rounds before stop"}, 32'(rounds), 32'(k_exp));
    check({req, " R4 done"}, 32'(done), 1);
    check({req, " R5 response"}, 32'(response), 32'(exp_resp));
    repeat (15) @(negedge clk);
    check({req, " R9 done held"}, 32'(done), 1);
    check({req, " R9 response held"}, 32'(response), 32'(exp_resp));
  endtask

  task automatic t_reset();
    check("R1 osc_en", 32'(osc_en), 0);
    check("R1 done", 32'(done), 0);
    check("R1 response", 32'(response), 0);
  endtask

  task automatic t_basic();
    div = '{2, 1, 3, 1, 4, 2, 1, 3};
    sel = '{1, 2, 0, 4};
    run_case("R3 R5 basic", 0, 5, 0);
  endtask

  task automatic t_mixed();
    div = '{1, 3, 1, 2, 1, 1, 4, 2};
    sel = '{3, 6, 7, 5};
    run_case("R5 mixed", 3, 7, 0);
  endtask

  task automatic t_dup_sel();
    div = '{1, 3, 2, 2, 1, 1, 4, 2};
    sel = '{2, 2, 1, 1};
    run_case("R6 duplicate and timebase", 2, 4, 0);
  endtask

  task automatic t_zero();
    div = '{1, 1, 1, 1, 1, 1, 1, 1};
    sel = '{0, 3, 5, 7};
    run_case("R7 zero observation", 4, 0, 0);
  endtask

  task automatic t_saturate();
    div = '{3, 1, 1, 2, 3, 1, 2, 1};
    sel = '{1, 0, 3, 4};
    run_case("R8 saturate", 3, 40, 0);
  endtask

  task automatic t_inject();
    div = '{2, 1, 3, 1, 4, 2, 1, 3};
    sel = '{1, 2, 0, 4};
    run_case("R10 inputs ignored in run", 0, 5, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_mixed();
    t_dup_sel();
    t_zero();
    t_saturate();
    t_inject();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule